// File: doc/BRIEF.md
# Write Data Phase Derivation Unit

This block turns the per-lane write strobe delays found by a completed write-leveling sweep into the remaining write-path settings. It works on each of nine byte lanes, and each delay is a 7-bit fraction of one clock period. For every lane it reports whether the strobe delay lies in the first half of the period. It also derives a write-data delay that sits a quarter period earlier, wrapping around the period boundary, and reports whether that write-data delay lies in the first half of the period.

After the per-lane step, the block compares all lanes together. It looks for a split in which some write-data delays fall just below the half-period point and others fall just above it. The width of "just" is set by a window input. When such a split exists, every lane whose write-data delay is in the upper half gets an extra write clock delay bit. The write-data PHY latency and the read-data latency are each lowered by one cycle.

A one-cycle start pulse captures the inputs. Every result is registered and is reported with a one-cycle valid pulse on the following clock. The results then hold until the next start.

Top module: `wdp_phase_derive`

## Requirements
- R1: The strobe below-half flag of a lane is 1 exactly when that lane's strobe delay is less than 0x40 (bit 6 of the delay clear).
- R2: The write-data delay of a lane is the strobe delay minus 0x20 when the strobe delay is above 0x20. Otherwise it is the strobe delay plus 0x60, taken modulo 128, so 0x20 maps to 0x00 and 0x00 maps to 0x60.
- R3: The write-data below-half flag of a lane is 1 exactly when that lane's write-data delay is less than 0x40.
- R4: A split is reported on `straddle_o` when at least one lane's write-data delay lies in [0x40-w, 0x3F] and at least one lies in [0x40, 0x40+w]. Here w is the 6-bit `near_win_i` value.
- R5: When a split is reported, a lane's write clock delay bit is 1 exactly when that lane's write-data below-half flag is 0.
- R6: When a split is reported, the write and read latency outputs are the captured inputs minus one, held at 0 when the input is 0.
- R7: When no split is reported, all write clock delay bits are 0 and both latency outputs equal the captured inputs.
- R8: `valid_o` is high for exactly the cycle after a cycle with `start_i` high, and low otherwise.
- R9: Outputs change only on a start. Input changes without a start leave every output unchanged.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture pulse |
| wrdqs_dly_i | input | 63 | Strobe delays, lane k in bits [7k+6:7k] |
| near_win_i | input | 6 | Half-period proximity window w |
| wr_lat_i | input | 6 | Write-data PHY latency before adjustment |
| rd_lat_i | input | 6 | Read-data latency before adjustment |
| valid_o | output | 1 | Results updated this cycle |
| straddle_o | output | 1 | Cross-lane split found |
| wrdqs_lt_half_o | output | 9 | Per-lane strobe below-half flags |
| wrdata_dly_o | output | 63 | Per-lane write-data delays, same packing as input |
| wrdata_lt_half_o | output | 9 | Per-lane write-data below-half flags |
| wclk_dly_o | output | 9 | Per-lane write clock delay bits |
| wr_lat_o | output | 6 | Adjusted write-data PHY latency |
| rd_lat_o | output | 6 | Adjusted read-data latency |

## Verification
The bench sweeps every strobe value 0..127 across lanes with rotating offsets, so the wrap points at 0x20 and 0x21 and the half point at 0x3F and 0x40 are all hit. A design with an off-by-one at 0x20, or one that drops the modulo, would show the wrong delay for those lanes. It also walks the window edges for each w from 0 to 8, placing lanes at exactly 0x40-w and 0x40+w and then one step outside them. An inclusive/exclusive mistake would report a split that does not exist or miss one that does. Zero latency inputs during a split expose a decrement that wraps instead of holding at 0. Input changes without a start expose outputs that are not truly held.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  // Quarter-period earlier position, wrapped into the period (dw bits).
  function automatic int unsigned wrdata_of(int unsigned d, int unsigned dw);
    int unsigned q;
    int unsigned m;
    q = 1 << (dw - 2);
    m = (1 << dw) - 1;
    if (d > q) return (d - q) & m;
    else       return (d + 3 * q) & m;
  endfunction

  // Just below the half point, within w steps.
  function automatic logic near_below(int unsigned d, int unsigned w, int unsigned dw);
    int unsigned h;
    h = 1 << (dw - 1);
    return (d < h) && (d + w >= h);
  endfunction

  // At or just above the half point, within w steps.
  function automatic logic near_above(int unsigned d, int unsigned w, int unsigned dw);
    int unsigned h;
    h = 1 << (dw - 1);
    return (d >= h) && (d <= h + w);
  endfunction

endpackage

// File: rtl/wdp_lane_map.sv
module wdp_lane_map #(
  parameter int DLY_W = 7
) (
  input  logic [DLY_W-1:0] wrdqs_dly,
  output logic             wrdqs_lt_half,
  output logic [DLY_W-1:0] wrdata_dly,
  output logic             wrdata_lt_half
);
  always_comb begin
    wrdqs_lt_half  = ~wrdqs_dly[DLY_W-1];
    wrdata_dly     = DLY_W'(wdp_pkg::wrdata_of(32'(wrdqs_dly), DLY_W));
    wrdata_lt_half = ~wrdata_dly[DLY_W-1];
  end
endmodule

// File: rtl/wdp_straddle_det.sv
module wdp_straddle_det #(
  parameter int NUM_LANES = 9,
  parameter int DLY_W     = 7
) (
  input  logic [NUM_LANES*DLY_W-1:0] wrdata_dly,
  input  logic [DLY_W-2:0]           near_win,
  output logic                       any_below,
  output logic                       any_above,
  output logic                       straddle
);
  logic [NUM_LANES-1:0] hit_below;
  logic [NUM_LANES-1:0] hit_above;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    always_comb begin
      hit_below[k] = wdp_pkg::near_below(32'(wrdata_dly[k*DLY_W +: DLY_W]),
                                         32'(near_win), DLY_W);
      hit_above[k] = wdp_pkg::near_above(32'(wrdata_dly[k*DLY_W +: DLY_W]),
                                         32'(near_win), DLY_W);
    end
  end

  assign any_below = |hit_below;
  assign any_above = |hit_above;
  assign straddle  = any_below & any_above;
endmodule

// File: rtl/wdp_lat_adj.sv
module wdp_lat_adj #(
  parameter int LAT_W = 6
) (
  input  logic [LAT_W-1:0] lat_in,
  input  logic             dec,
  output logic [LAT_W-1:0] lat_out
);
  always_comb begin
    if (dec && (lat_in != '0)) lat_out = lat_in - 1'b1;
    else                       lat_out = lat_in;
  end
endmodule

// File: rtl/wdp_phase_derive.sv
module wdp_phase_derive #(
  parameter int NUM_LANES = 9,
  parameter int DLY_W     = 7,
  parameter int LAT_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [NUM_LANES*DLY_W-1:0] wrdqs_dly_i,
  input  logic [DLY_W-2:0]           near_win_i,
  input  logic [LAT_W-1:0]           wr_lat_i,
  input  logic [LAT_W-1:0]           rd_lat_i,
  output logic                       valid_o,
  output logic                       straddle_o,
  output logic [NUM_LANES-1:0]       wrdqs_lt_half_o,
  output logic [NUM_LANES*DLY_W-1:0] wrdata_dly_o,
  output logic [NUM_LANES-1:0]       wrdata_lt_half_o,
  output logic [NUM_LANES-1:0]       wclk_dly_o,
  output logic [LAT_W-1:0]           wr_lat_o,
  output logic [LAT_W-1:0]           rd_lat_o
);
  localparam int VEC_W = NUM_LANES * DLY_W;

  // Named combinational events.
  logic [NUM_LANES-1:0] nx_dqs_lt;
  logic [VEC_W-1:0]     nx_wd;
  logic [NUM_LANES-1:0] nx_wd_lt;
  logic                 nx_any_below;
  logic                 nx_any_above;
  logic                 nx_straddle;
  logic [NUM_LANES-1:0] nx_wclk;
  logic [LAT_W-1:0]     nx_wr_lat;
  logic [LAT_W-1:0]     nx_rd_lat;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_map
    wdp_lane_map #(.DLY_W(DLY_W)) u_map (
      .wrdqs_dly      (wrdqs_dly_i[k*DLY_W +: DLY_W]),
      .wrdqs_lt_half  (nx_dqs_lt[k]),
      .wrdata_dly     (nx_wd[k*DLY_W +: DLY_W]),
      .wrdata_lt_half (nx_wd_lt[k])
    );
  end

  wdp_straddle_det #(.NUM_LANES(NUM_LANES), .DLY_W(DLY_W)) u_det (
    .wrdata_dly (nx_wd),
    .near_win   (near_win_i),
    .any_below  (nx_any_below),
    .any_above  (nx_any_above),
    .straddle   (nx_straddle)
  );

  assign nx_wclk = nx_straddle ? ~nx_wd_lt : '0;

  wdp_lat_adj #(.LAT_W(LAT_W)) u_wr_lat (
    .lat_in (wr_lat_i), .dec (nx_straddle), .lat_out (nx_wr_lat)
  );
  wdp_lat_adj #(.LAT_W(LAT_W)) u_rd_lat (
    .lat_in (rd_lat_i), .dec (nx_straddle), .lat_out (nx_rd_lat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o          <= 1'b0;
      straddle_o       <= 1'b0;
      wrdqs_lt_half_o  <= '0;
      wrdata_dly_o     <= '0;
      wrdata_lt_half_o <= '0;
      wclk_dly_o       <= '0;
      wr_lat_o         <= '0;
      rd_lat_o         <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        straddle_o       <= nx_straddle;
        wrdqs_lt_half_o  <= nx_dqs_lt;
        wrdata_dly_o     <= nx_wd;
        wrdata_lt_half_o <= nx_wd_lt;
        wclk_dly_o       <= nx_wclk;
        wr_lat_o         <= nx_wr_lat;
        rd_lat_o         <= nx_rd_lat;
      end
    end
  end
endmodule

// File: rtl/wdp_phase_derive_chk.sv
module wdp_phase_derive_chk #(
  parameter int NUM_LANES = 9,
  parameter int DLY_W     = 7,
  parameter int LAT_W     = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic [LAT_W-1:0]           wr_lat_i,
  input logic [LAT_W-1:0]           rd_lat_i,
  input logic                       valid_o,
  input logic                       straddle_o,
  input logic [NUM_LANES*DLY_W-1:0] wrdata_dly_o,
  input logic [NUM_LANES-1:0]       wrdata_lt_half_o,
  input logic [NUM_LANES-1:0]       wclk_dly_o,
  input logic [LAT_W-1:0]           wr_lat_o,
  input logic [LAT_W-1:0]           rd_lat_o
);
  p_valid_follows_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  p_valid_only_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  p_hold_without_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(wrdata_dly_o) && $stable(wclk_dly_o) && $stable(wr_lat_o)
                  && $stable(rd_lat_o) && $stable(straddle_o)));

  p_wclk_upper_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && straddle_o) |-> (wclk_dly_o == ~wrdata_lt_half_o));

  p_lat_sat_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && straddle_o) |->
      ((wr_lat_o == (($past(wr_lat_i) == '0) ? '0 : $past(wr_lat_i) - 1'b1)) &&
       (rd_lat_o == (($past(rd_lat_i) == '0) ? '0 : $past(rd_lat_i) - 1'b1))));

  p_no_split_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !straddle_o) |->
      ((wclk_dly_o == '0) && (wr_lat_o == $past(wr_lat_i)) && (rd_lat_o == $past(rd_lat_i))));
endmodule

bind wdp_phase_derive wdp_phase_derive_chk #(
  .NUM_LANES(NUM_LANES), .DLY_W(DLY_W), .LAT_W(LAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_lat_i(wr_lat_i), .rd_lat_i(rd_lat_i),
  .valid_o(valid_o), .straddle_o(straddle_o), .wrdata_dly_o(wrdata_dly_o),
  .wrdata_lt_half_o(wrdata_lt_half_o), .wclk_dly_o(wclk_dly_o),
  .wr_lat_o(wr_lat_o), .rd_lat_o(rd_lat_o)
);

// File: tb/wdp_phase_derive_bench.sv
module wdp_phase_derive_bench;
  localparam int NL = 9;
  localparam int DW = 7;
  localparam int LW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [NL*DW-1:0] wrdqs_dly_i = '0;
  logic [DW-2:0]   near_win_i = '0;
  logic [LW-1:0]   wr_lat_i = '0;
  logic [LW-1:0]   rd_lat_i = '0;
  logic            valid_o, straddle_o;
  logic [NL-1:0]   wrdqs_lt_half_o, wrdata_lt_half_o, wclk_dly_o;
  logic [NL*DW-1:0] wrdata_dly_o;
  logic [LW-1:0]   wr_lat_o, rd_lat_o;

  int tests = 0;
  int fails = 0;
  int lane_d [NL];

  always #5 clk = ~clk;

  wdp_phase_derive u_wdp_phase_derive (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wrdqs_dly_i(wrdqs_dly_i),
    .near_win_i(near_win_i), .wr_lat_i(wr_lat_i), .rd_lat_i(rd_lat_i),
    .valid_o(valid_o), .straddle_o(straddle_o), .wrdqs_lt_half_o(wrdqs_lt_half_o),
    .wrdata_dly_o(wrdata_dly_o), .wrdata_lt_half_o(wrdata_lt_half_o),
    .wclk_dly_o(wclk_dly_o), .wr_lat_o(wr_lat_o), .rd_lat_o(rd_lat_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_wd(int d);
    int r;
    r = (d <= 32) ? d + 96 : d - 32;
    return r % 128;
  endfunction

  // Drive lane_d with window w and latencies, pulse start, check results.
  task automatic run(input int w, input int wl, input int rl);
    logic [NL*DW-1:0] e_wd;
    logic [NL-1:0] e_dqs_lt, e_wd_lt, e_wclk;
    bit lo, hi, split;
    int ewl, erl;
    lo = 0; hi = 0;
    for (int k = 0; k < NL; k++) begin
      int wd;
      wd = exp_wd(lane_d[k]);
      e_wd[k*DW +: DW] = DW'(wd);
      e_dqs_lt[k] = (lane_d[k] < 64);
      e_wd_lt[k]  = (wd < 64);
      if (wd >= 64 - w && wd <= 63) lo = 1;
      if (wd >= 64 && wd <= 64 + w) hi = 1;
    end
    split = lo && hi;
    e_wclk = split ? ~e_wd_lt : '0;
    ewl = (split && wl > 0) ? wl - 1 : wl;
    erl = (split && rl > 0) ? rl - 1 : rl;

    @(negedge clk);
    for (int k = 0; k < NL; k++) wrdqs_dly_i[k*DW +: DW] = DW'(lane_d[k]);
    near_win_i = (DW-1)'(w);
    wr_lat_i = LW'(wl);
    rd_lat_i = LW'(rl);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 valid after start", 64'(valid_o), 64'(1));
    chk("R1 strobe below-half", 64'(wrdqs_lt_half_o), 64'(e_dqs_lt));
    chk("R2 write-data delay", 64'(wrdata_dly_o), 64'(e_wd));
    chk("R3 write-data below-half", 64'(wrdata_lt_half_o), 64'(e_wd_lt));
    chk("R4 split", 64'(straddle_o), 64'(split));
    chk(split ? "R5 clock delay bits" : "R7 clock delay bits", 64'(wclk_dly_o), 64'(e_wclk));
    chk(split ? "R6 write latency" : "R7 write latency", 64'(wr_lat_o), 64'(ewl));
    chk(split ? "R6 read latency" : "R7 read latency", 64'(rd_lat_o), 64'(erl));
    // R9: disturb inputs without start; outputs must hold.
    wrdqs_dly_i = ~wrdqs_dly_i;
    wr_lat_i = ~wr_lat_i;
    rd_lat_i = ~rd_lat_i;
    near_win_i = ~near_win_i;
    @(negedge clk);
    chk("R8 valid low without start", 64'(valid_o), 64'(0));
    chk("R9 delay held", 64'(wrdata_dly_o), 64'(e_wd));
    chk("R9 latency held", {52'(0), wr_lat_o, rd_lat_o}, {52'(0), LW'(ewl), LW'(erl)});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs",
        {valid_o, straddle_o, wrdqs_lt_half_o, wrdata_lt_half_o, wclk_dly_o, wr_lat_o, rd_lat_o},
        '0);
    chk("R10 reset delay", 64'(wrdata_dly_o), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 still idle after reset", 64'(valid_o), 64'(0));

    // Sweep every strobe value with rotated lanes.
    for (int v = 0; v < 128; v++) begin
      for (int k = 0; k < NL; k++) lane_d[k] = (v + 13 * k) % 128;
      run(v % 16, v % 4, (v * 3) % 64);
    end

    // Window edge walk: write-data target t uses strobe t+0x20.
    for (int w = 0; w <= 8; w++) begin
      for (int k = 0; k < NL; k++) lane_d[k] = 0;     // write-data 0x60, far away
      lane_d[0] = 64 - w + 32;
      lane_d[1] = 64 + w + 32;
      run(w, w % 2, 1);                                // on both edges: split
      lane_d[0] = 64 - w - 1 + 32;
      run(w, 3, 0);                                    // below edge outside
      lane_d[0] = 64 - w + 32;
      lane_d[1] = 64 + w + 1 + 32;
      run(w, 0, 5);                                    // above edge outside
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule